// File: doc/BRIEF.md
# Plane Readout and Noise-Monitor Sequencer

This block is the timing controller for reading out one detector plane. A final-trigger pulse from the trigger logic makes it send a one-cycle latch command to every front-end board, which freezes the strip hit pattern. The block then drives a shift clock with a programmed pulse count and a programmed half-period, so the latched bits move along the daisy chain of front-end boards into the readout module. When the last pulse has gone, a one-cycle done flag is raised. A trigger that arrives while the sequencer is busy is dropped and counted.

The same engine also runs noise-rate monitoring. An internal period timer emits a one-cycle interrupt each time it expires. On that interrupt a channel-select output steps to the next strip, and it wraps at the channel count, so the external rate scalers see each strip in turn. A small write-only register port sets the half-period of the shift clock, the transfer length and the monitor period. Through the same port a host can fire a single latch command or a single shift pulse with no trigger, for bench diagnostics.

Top module: `rdo_sequencer`

## Requirements
- R1: A trigger sampled while idle makes `latch_o` high for exactly one cycle, the cycle after the sampling edge.
- R2: A transfer of length N makes N shift-clock pulses. `done_o` is high for one cycle, starting 2·H·N cycles after the latch cycle began (H is the half-period). `busy_o` is high from the latch cycle up to, but not including, the done cycle.
- R3: `sclk_o` is low while idle. Each transfer pulse is H cycles low and then H cycles high, and the first low phase starts with the latch cycle. A speed value of 0 acts as 1.
- R4: A trigger sampled while busy produces no latch and does not restart or stretch the transfer in progress.
- R5: `lost_cnt_o` resets to 0 and counts each trigger sampled while busy. It saturates at 2^LOST_W−1.
- R6: When the monitor period P is nonzero, `mon_irq_o` pulses for one cycle every P cycles. The first pulse comes P cycles after the write that set P, because writing the period restarts the timer. With P = 0 no pulse is produced.
- R7: `mon_sel_o` resets to 0 and changes only in an interrupt cycle. In that cycle it advances by one, modulo NCH.
- R8: Register addresses are 0 for speed (half-period in clock cycles), 1 for length (pulse count), 2 for the monitor period and 3 for diagnostics. Reset values are 1, 16 and 0. Speed and length are captured when a transfer starts, so a write made during a transfer only affects later transfers.
- R9: A write to address 3 while idle works as follows. Data bit 0 gives one latch pulse. Data bit 1 gives one shift-clock high phase of H cycles, starting the cycle after the write, with busy high during it and no done. Such a write is ignored while busy, and a trigger in the same cycle takes priority.
- R10: A trigger with length 0 gives a latch with `done_o` in the same cycle. No shift pulse follows and `busy_o` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released in step with clk |
| trig_i | input | 1 | Final-trigger pulse, sampled each cycle |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | WD_W | Register write data (width of the widest field) |
| latch_o | output | 1 | Latch command to all front-end boards |
| sclk_o | output | 1 | Shift clock for the front-end daisy chain |
| busy_o | output | 1 | Transfer or diagnostic step in progress |
| done_o | output | 1 | One-cycle end-of-transfer flag |
| lost_cnt_o | output | LOST_W | Saturating count of ignored triggers |
| mon_irq_o | output | 1 | One-cycle monitor timer interrupt |
| mon_sel_o | output | clog2(NCH) | Strip selected for rate monitoring |

## Verification
The bench builds the block with NCH = 5, so the channel select has to wrap at a value that is not a power of two. A 4-bit speed field is used so that the zero-speed clamp and multi-cycle half-periods can both be driven. A 6-bit period field keeps interrupt spacing short, so many wraps fit in a few hundred cycles. A 3-bit lost counter lets a held trigger drive it into saturation. Length and speed writes landing mid-transfer, back-to-back triggers and zero-length transfers can then all be compared cycle by cycle against a behavioural model.

// File: rtl/rdo_pkg.sv
package rdo_pkg;

  typedef enum logic [1:0] {
    XS_IDLE  = 2'd0,
    XS_SHIFT = 2'd1,
    XS_STEP  = 2'd2
  } xfer_state_e;

  localparam logic [1:0] ADDR_SPEED  = 2'd0;
  localparam logic [1:0] ADDR_LENGTH = 2'd1;
  localparam logic [1:0] ADDR_PERIOD = 2'd2;
  localparam logic [1:0] ADDR_DIAG   = 2'd3;

  localparam int DIAG_LATCH_BIT = 0;
  localparam int DIAG_STEP_BIT  = 1;

endpackage

// File: rtl/rdo_cfg_regs.sv
module rdo_cfg_regs
  import rdo_pkg::*;
#(
  parameter int SPD_W   = 8,
  parameter int LEN_W   = 10,
  parameter int PER_W   = 16,
  parameter int WD_W    = 16,
  parameter int SPD_RST = 1,
  parameter int LEN_RST = 16,
  parameter int PER_RST = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [WD_W-1:0]  wr_data,
  output logic [SPD_W-1:0] spd_o,
  output logic [LEN_W-1:0] len_o,
  output logic [PER_W-1:0] per_o,
  output logic             per_wr_o,
  output logic             diag_latch_o,
  output logic             diag_step_o
);

  logic             spd_en, len_en, per_en, diag_en;
  logic [SPD_W-1:0] spd_q;
  logic [LEN_W-1:0] len_q;
  logic [PER_W-1:0] per_q;

  always_comb begin
    spd_en  = wr_en && (wr_addr == ADDR_SPEED);
    len_en  = wr_en && (wr_addr == ADDR_LENGTH);
    per_en  = wr_en && (wr_addr == ADDR_PERIOD);
    diag_en = wr_en && (wr_addr == ADDR_DIAG);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      spd_q <= SPD_W'(SPD_RST);
      len_q <= LEN_W'(LEN_RST);
      per_q <= PER_W'(PER_RST);
    end else begin
      if (spd_en) spd_q <= wr_data[SPD_W-1:0];
      if (len_en) len_q <= wr_data[LEN_W-1:0];
      if (per_en) per_q <= wr_data[PER_W-1:0];
    end
  end

  assign spd_o        = spd_q;
  assign len_o        = len_q;
  assign per_o        = per_q;
  assign per_wr_o     = per_en;
  assign diag_latch_o = diag_en && wr_data[DIAG_LATCH_BIT];
  assign diag_step_o  = diag_en && wr_data[DIAG_STEP_BIT];

endmodule

// File: rtl/rdo_xfer_engine.sv
module rdo_xfer_engine
  import rdo_pkg::*;
#(
  parameter int SPD_W  = 8,
  parameter int LEN_W  = 10,
  parameter int LOST_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trig_i,
  input  logic              diag_latch_i,
  input  logic              diag_step_i,
  input  logic [SPD_W-1:0]  cfg_spd_i,
  input  logic [LEN_W-1:0]  cfg_len_i,
  output logic              latch_o,
  output logic              sclk_o,
  output logic              busy_o,
  output logic              done_o,
  output logic [LOST_W-1:0] lost_o
);

  localparam logic [LOST_W-1:0] LOST_MAX = {LOST_W{1'b1}};

  xfer_state_e       st_q, st_d;
  logic [SPD_W-1:0]  hcnt_q, hcnt_d, hlim_q, hlim_d;
  logic [LEN_W-1:0]  pcnt_q, pcnt_d, nlim_q, nlim_d;
  logic              sclk_q, sclk_d, latch_q, latch_d, done_q, done_d;
  logic [LOST_W-1:0] lost_q, lost_d;
  logic              half_end;
  logic [SPD_W-1:0]  spd_lim;

  always_comb begin
    half_end = (hcnt_q == hlim_q);
    spd_lim  = (cfg_spd_i == '0) ? '0 : cfg_spd_i - 1'b1;
  end

  always_comb begin
    st_d    = st_q;
    hcnt_d  = hcnt_q;
    hlim_d  = hlim_q;
    pcnt_d  = pcnt_q;
    nlim_d  = nlim_q;
    sclk_d  = sclk_q;
    latch_d = 1'b0;
    done_d  = 1'b0;
    lost_d  = lost_q;
    unique case (st_q)
      XS_IDLE: begin
        if (trig_i) begin
          latch_d = 1'b1;
          hlim_d  = spd_lim;
          nlim_d  = cfg_len_i - 1'b1;
          hcnt_d  = '0;
          pcnt_d  = '0;
          sclk_d  = 1'b0;
          if (cfg_len_i == '0) done_d = 1'b1;
          else                 st_d   = XS_SHIFT;
        end else if (diag_latch_i || diag_step_i) begin
          latch_d = diag_latch_i;
          if (diag_step_i) begin
            hlim_d = spd_lim;
            hcnt_d = '0;
            sclk_d = 1'b1;
            st_d   = XS_STEP;
          end
        end
      end
      XS_SHIFT: begin
        if (half_end) begin
          hcnt_d = '0;
          sclk_d = !sclk_q;
          if (sclk_q) begin
            if (pcnt_q == nlim_q) begin
              st_d   = XS_IDLE;
              done_d = 1'b1;
            end else begin
              pcnt_d = pcnt_q + 1'b1;
            end
          end
        end else begin
          hcnt_d = hcnt_q + 1'b1;
        end
      end
      XS_STEP: begin
        if (half_end) begin
          sclk_d = 1'b0;
          st_d   = XS_IDLE;
        end else begin
          hcnt_d = hcnt_q + 1'b1;
        end
      end
      default: st_d = XS_IDLE;
    endcase
    if (trig_i && (st_q != XS_IDLE) && (lost_q != LOST_MAX)) begin
      lost_d = lost_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= XS_IDLE;
      hcnt_q  <= '0;
      hlim_q  <= '0;
      pcnt_q  <= '0;
      nlim_q  <= '0;
      sclk_q  <= 1'b0;
      latch_q <= 1'b0;
      done_q  <= 1'b0;
      lost_q  <= '0;
    end else begin
      st_q    <= st_d;
      hcnt_q  <= hcnt_d;
      hlim_q  <= hlim_d;
      pcnt_q  <= pcnt_d;
      nlim_q  <= nlim_d;
      sclk_q  <= sclk_d;
      latch_q <= latch_d;
      done_q  <= done_d;
      lost_q  <= lost_d;
    end
  end

  assign latch_o = latch_q;
  assign sclk_o  = sclk_q;
  assign busy_o  = (st_q != XS_IDLE);
  assign done_o  = done_q;
  assign lost_o  = lost_q;

  AST_IDLE_TRIG_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == XS_IDLE && trig_i) |=> latch_o); // R1

  AST_BUSY_NO_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != XS_IDLE) |=> !latch_o); // R4

  AST_SCLK_LOW_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == XS_IDLE) |-> !sclk_o); // R3

  AST_PULSE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == XS_SHIFT) |-> (pcnt_q <= nlim_q)); // R2

  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o); // R2

  AST_LOST_MONOTONIC: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (lost_o >= $past(lost_o))); // R5

endmodule

// File: rtl/rdo_mon_timer.sv
module rdo_mon_timer #(
  parameter int PER_W = 16,
  parameter int NCH   = 32,
  localparam int CHW  = $clog2(NCH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PER_W-1:0] per_i,
  input  logic             restart_i,
  output logic             irq_o,
  output logic [CHW-1:0]   sel_o
);

  localparam logic [CHW-1:0] SEL_LAST = CHW'(NCH - 1);

  logic [PER_W-1:0] cnt_q, cnt_d;
  logic [CHW-1:0]   sel_q, sel_d;
  logic             irq_q, irq_d;

  always_comb begin
    cnt_d = cnt_q;
    sel_d = sel_q;
    irq_d = 1'b0;
    if (restart_i) begin
      cnt_d = '0;
    end else if (per_i != '0) begin
      if (cnt_q >= per_i - 1'b1) begin
        cnt_d = '0;
        irq_d = 1'b1;
        sel_d = (sel_q == SEL_LAST) ? '0 : sel_q + 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      sel_q <= '0;
      irq_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      sel_q <= sel_d;
      irq_q <= irq_d;
    end
  end

  assign irq_o = irq_q;
  assign sel_o = sel_q;

  AST_SEL_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(sel_o) < NCH)); // R7

  AST_SEL_HOLDS_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_o |-> (sel_o == $past(sel_o))); // R7

  AST_NO_IRQ_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (per_i == '0) |=> !irq_o); // R6

  AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && per_i > 1) |=> !irq_o); // R6

endmodule

// File: rtl/rdo_sequencer.sv
module rdo_sequencer #(
  parameter int SPD_W   = 8,
  parameter int LEN_W   = 10,
  parameter int PER_W   = 16,
  parameter int LOST_W  = 8,
  parameter int NCH     = 32,
  parameter int SPD_RST = 1,
  parameter int LEN_RST = 16,
  parameter int PER_RST = 0,
  localparam int WD_A   = (SPD_W > LEN_W) ? SPD_W : LEN_W,
  localparam int WD_B   = (WD_A > PER_W) ? WD_A : PER_W,
  localparam int WD_W   = (WD_B > 2) ? WD_B : 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    trig_i,
  input  logic                    reg_we_i,
  input  logic [1:0]              reg_addr_i,
  input  logic [WD_W-1:0]         reg_wdata_i,
  output logic                    latch_o,
  output logic                    sclk_o,
  output logic                    busy_o,
  output logic                    done_o,
  output logic [LOST_W-1:0]       lost_cnt_o,
  output logic                    mon_irq_o,
  output logic [$clog2(NCH)-1:0]  mon_sel_o
);

  logic [SPD_W-1:0] cfg_spd;
  logic [LEN_W-1:0] cfg_len;
  logic [PER_W-1:0] cfg_per;
  logic             per_wr, diag_latch, diag_step;

  rdo_cfg_regs #(
    .SPD_W(SPD_W), .LEN_W(LEN_W), .PER_W(PER_W), .WD_W(WD_W),
    .SPD_RST(SPD_RST), .LEN_RST(LEN_RST), .PER_RST(PER_RST)
  ) u_regs (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (reg_we_i),
    .wr_addr      (reg_addr_i),
    .wr_data      (reg_wdata_i),
    .spd_o        (cfg_spd),
    .len_o        (cfg_len),
    .per_o        (cfg_per),
    .per_wr_o     (per_wr),
    .diag_latch_o (diag_latch),
    .diag_step_o  (diag_step)
  );

  rdo_xfer_engine #(
    .SPD_W(SPD_W), .LEN_W(LEN_W), .LOST_W(LOST_W)
  ) u_xfer (
    .clk          (clk),
    .rst_n        (rst_n),
    .trig_i       (trig_i),
    .diag_latch_i (diag_latch),
    .diag_step_i  (diag_step),
    .cfg_spd_i    (cfg_spd),
    .cfg_len_i    (cfg_len),
    .latch_o      (latch_o),
    .sclk_o       (sclk_o),
    .busy_o       (busy_o),
    .done_o       (done_o),
    .lost_o       (lost_cnt_o)
  );

  rdo_mon_timer #(
    .PER_W(PER_W), .NCH(NCH)
  ) u_mon (
    .clk       (clk),
    .rst_n     (rst_n),
    .per_i     (cfg_per),
    .restart_i (per_wr),
    .irq_o     (mon_irq_o),
    .sel_o     (mon_sel_o)
  );

endmodule

// File: tb/rdo_sequencer_tb.sv
`timescale 1ns/1ps
module rdo_sequencer_tb;

  localparam int NCH  = 5;
  localparam int LMAX = 7;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       trig;
  logic       we;
  logic [1:0] addr;
  logic [5:0] wdata;
  logic       latch, sclk, busy, done, irq;
  logic [2:0] lost;
  logic [2:0] sel;

  always #5 clk = ~clk;

  rdo_sequencer #(
    .SPD_W(4), .LEN_W(5), .PER_W(6), .LOST_W(3), .NCH(NCH)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .trig_i(trig), .reg_we_i(we),
    .reg_addr_i(addr), .reg_wdata_i(wdata), .latch_o(latch),
    .sclk_o(sclk), .busy_o(busy), .done_o(done), .lost_cnt_o(lost),
    .mon_irq_o(irq), .mon_sel_o(sel)
  );

  int    n_chk = 0, n_fail = 0;
  bit    fin = 0;
  string ph = "R8";

  // behavioural reference: mode 0 idle, 1 transfer, 2 diagnostic step
  int m_mode, m_k, m_H, m_N, m_lost, m_mcnt, m_sel, m_spd, m_len, m_per;
  bit e_latch, e_done, e_irq;

  always @(posedge clk or negedge rst_n) begin : model
    bit was_busy;
    if (!rst_n) begin
      m_mode = 0; m_k = 0; m_H = 1; m_N = 0; m_lost = 0; m_mcnt = 0; m_sel = 0;
      m_spd = 1; m_len = 16; m_per = 0;
      e_latch = 0; e_done = 0; e_irq = 0;
    end else begin
      was_busy = (m_mode != 0);
      e_latch = 0; e_done = 0; e_irq = 0;
      if (m_mode == 1) begin
        m_k++;
        if (m_k == 2 * m_H * m_N) begin m_mode = 0; e_done = 1; end
      end else if (m_mode == 2) begin
        m_k++;
        if (m_k == m_H) m_mode = 0;
      end
      if (trig && was_busy) begin
        if (m_lost < LMAX) m_lost++;
      end else if (!was_busy && trig) begin
        e_latch = 1;
        m_H = (m_spd == 0) ? 1 : m_spd;
        m_N = m_len;
        if (m_N == 0) e_done = 1;
        else begin m_mode = 1; m_k = 0; end
      end else if (!was_busy && we && addr == 2'd3 && (wdata[0] || wdata[1])) begin
        e_latch = wdata[0];
        if (wdata[1]) begin
          m_H = (m_spd == 0) ? 1 : m_spd;
          m_mode = 2; m_k = 0;
        end
      end
      if (we && addr == 2'd2) m_mcnt = 0;
      else if (m_per != 0) begin
        if (m_mcnt + 1 >= m_per) begin
          m_mcnt = 0; e_irq = 1; m_sel = (m_sel + 1) % NCH;
        end else m_mcnt++;
      end
      if (we) begin
        if (addr == 2'd0) m_spd = int'(wdata[3:0]);
        if (addr == 2'd1) m_len = int'(wdata[4:0]);
        if (addr == 2'd2) m_per = int'(wdata[5:0]);
      end
    end
  end

  task automatic chk(input int act, input int exp, input string req, input string sig);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s (%s) %s at %0t: actual %0d expected %0d", req, ph, sig, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    int e_sclk;
    if (!fin) begin
      e_sclk = (m_mode == 1) ? (((m_k / m_H) % 2 == 1) ? 1 : 0) : (m_mode == 2 ? 1 : 0);
      chk(int'(latch), int'(e_latch), "R1", "latch_o");
      chk(int'(sclk),  e_sclk,        "R3", "sclk_o");
      chk(int'(busy),  (m_mode != 0) ? 1 : 0, "R2", "busy_o");
      chk(int'(done),  int'(e_done),  "R2", "done_o");
      chk(int'(lost),  m_lost,        "R5", "lost_cnt_o");
      chk(int'(irq),   int'(e_irq),   "R6", "mon_irq_o");
      chk(int'(sel),   m_sel,         "R7", "mon_sel_o");
    end
  end

  task automatic tick();
    @(negedge clk); #1;
  endtask

  task automatic idle(input int n);
    repeat (n) tick();
  endtask

  task automatic wr(input logic [1:0] a, input logic [5:0] d);
    we = 1'b1; addr = a; wdata = d;
    tick();
    we = 1'b0; addr = 2'd0; wdata = '0;
  endtask

  task automatic pulse_trig();
    trig = 1'b1; tick(); trig = 1'b0;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    rst_n = 1'b0; trig = 1'b0; we = 1'b0; addr = 2'd0; wdata = '0;
    idle(3);
    rst_n = 1'b1;
    ph = "R8"; idle(4);                      // reset config: speed 1, length 16, period off
    ph = "R1"; pulse_trig(); idle(40);
    ph = "R8"; wr(2'd0, 6'd3); wr(2'd1, 6'd4);
    pulse_trig(); idle(5); wr(2'd1, 6'd2); idle(30);
    pulse_trig(); idle(20);
    ph = "R4"; pulse_trig(); idle(3); pulse_trig(); wr(2'd3, 6'd3); idle(30);
    ph = "R5"; wr(2'd0, 6'd1); wr(2'd1, 6'd1);
    trig = 1'b1; idle(20); trig = 1'b0; idle(6);
    ph = "R10"; wr(2'd1, 6'd0); pulse_trig(); idle(3); trig = 1'b1; idle(2); trig = 1'b0; idle(3);
    ph = "R9"; wr(2'd3, 6'd1); idle(3);
    wr(2'd0, 6'd2); wr(2'd3, 6'd2); idle(5);
    wr(2'd3, 6'd3); idle(5);
    wr(2'd1, 6'd1);
    trig = 1'b1; we = 1'b1; addr = 2'd3; wdata = 6'd3; tick();
    trig = 1'b0; we = 1'b0; addr = 2'd0; wdata = '0; idle(10);
    ph = "R6"; wr(2'd2, 6'd4); idle(30);
    wr(2'd2, 6'd3); idle(20);
    wr(2'd2, 6'd0); idle(10);
    wr(2'd2, 6'd1); idle(8);
    wr(2'd2, 6'd0); idle(3);
    ph = "R3"; wr(2'd0, 6'd0); wr(2'd1, 6'd3); pulse_trig(); idle(12);
    ph = "R7"; wr(2'd2, 6'd5); wr(2'd0, 6'd2); wr(2'd1, 6'd5);
    pulse_trig(); idle(8); pulse_trig(); idle(40);
    fin = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!fin) begin
      fin = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: run did not complete, actual hung expected finished");
      summary();
      $finish;
    end
  end

endmodule